// File: doc/BRIEF.md
# Data Bus Parking Controller

This block decides, cycle by cycle, whether a 16-bit bidirectional external data bus is driven and which value is driven onto it. While no read is in progress, the bus is held at the word from the most recent write. This keeps the pins from floating, so no external pull-ups are needed. The driver lets go of the bus only while a read is in flight, and it takes the bus back on the clock edge that samples the final read beat.

There is one exception. An asynchronous read issued while the memory controller reports self-refresh leaves the bus tri-stated after the read completes. The bus stays tri-stated until the next write beat or until self-refresh ends, whichever comes first. The command sequencer supplies the event strobes. The pad ring consumes the registered enable and data.

Top module: `dbus_park_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the bus is driven (`bus_oe`=1) with the value 0x0000.
- R2: A write beat (`wr_beat`=1) sampled at a clock edge makes `bus_dout` equal to `wr_data` from that edge onward. The whole word is captured even when the write touches only some bytes.
- R3: A read start (`rd_start`=1) sampled while the bus is driven clears `bus_oe` at that same edge, with no extra driven cycle.
- R4: During a read, `bus_oe` stays 0 until `rd_last` is sampled. A further `rd_start` during the read has no effect.
- R5: A read that is not a self-refresh asynchronous read sets `bus_oe` back to 1 at the edge that samples `rd_last`. The bus then carries the last written word.
- R6: A read started with `rd_async`=1 while `self_refresh`=1 leaves `bus_oe` at 0 after `rd_last`, and on following idle cycles.
- R7: From that tri-stated state, a write beat sets `bus_oe` to 1 with the new word at the edge that samples it.
- R8: From that tri-stated state, `self_refresh` going to 0 sets `bus_oe` to 1 with the previously parked word at the next edge.
- R9: Whether a read is a self-refresh asynchronous read is decided when the read starts. A synchronous read during self-refresh parks normally, and so does an asynchronous read outside self-refresh.
- R10: Without a write beat, `bus_dout` keeps its value across reads and idle cycles.
- R11: A write beat and a read start sampled at the same edge both take effect. The word is captured and the bus is released, and the next parking uses that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_beat | input | 1 | A write data beat is being driven this cycle |
| wr_data | input | 16 | Full data word of the write beat |
| rd_start | input | 1 | A read command is issued this cycle |
| rd_async | input | 1 | The issued read uses the asynchronous interface |
| rd_last | input | 1 | The final read data word is latched this cycle |
| self_refresh | input | 1 | The memory controller is in self-refresh |
| bus_oe | output | 1 | Registered data-bus driver enable (1 = drive) |
| bus_dout | output | 16 | Registered value driven onto the data bus |

## Verification
Every result is registered once, so each output responds at the same edge that samples its stimulus. A change requested in cycle k is visible from just after edge k until the next edge. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge, which is the first point where the new value is stable.

For the hold cases (R4, R6, R10), the bench adds further idle or repeated-command cycles and samples again on each one. This confirms that the state persists and was not only a single-cycle pulse.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  typedef enum logic [1:0] {
    ST_PARK  = 2'd0,
    ST_RDNRM = 2'd1,
    ST_RDSR  = 2'd2,
    ST_FLOAT = 2'd3
  } dbp_state_t;
endpackage

// File: rtl/dbp_value_reg.sv
module dbp_value_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/dbp_fsm.sv
module dbp_fsm
  import dbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_beat,
  input  logic       rd_start,
  input  logic       rd_async,
  input  logic       rd_last,
  input  logic       self_refresh,
  output dbp_state_t state,
  output logic       oe
);
  dbp_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_PARK: begin
        if (rd_start) nxt = (rd_async && self_refresh) ? ST_RDSR : ST_RDNRM;
      end
      ST_RDNRM: begin
        if (rd_last) nxt = ST_PARK;
      end
      ST_RDSR: begin
        if (rd_last) nxt = ST_FLOAT;
      end
      ST_FLOAT: begin
        if (rd_start)                     nxt = (rd_async && self_refresh) ? ST_RDSR : ST_RDNRM;
        else if (wr_beat || !self_refresh) nxt = ST_PARK;
      end
      default: nxt = ST_PARK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PARK;
      oe    <= 1'b1;
    end else begin
      state <= nxt;
      oe    <= (nxt == ST_PARK);
    end
  end
endmodule

// File: rtl/dbus_park_ctrl.sv
module dbus_park_ctrl
  import dbp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_beat,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_start,
  input  logic              rd_async,
  input  logic              rd_last,
  input  logic              self_refresh,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout
);
  dbp_state_t st;

  dbp_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_beat      (wr_beat),
    .rd_start     (rd_start),
    .rd_async     (rd_async),
    .rd_last      (rd_last),
    .self_refresh (self_refresh),
    .state        (st),
    .oe           (bus_oe)
  );

  dbp_value_reg #(.DW(DATA_W)) u_val (
    .clk  (clk),
    .rst  (rst),
    .load (wr_beat),
    .din  (wr_data),
    .dout (bus_dout)
  );
endmodule

// File: rtl/dbp_checker.sv
module dbp_checker
  import dbp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_beat,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_start,
  input logic              rd_last,
  input logic              self_refresh,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout,
  input dbp_state_t        st
);
  a_r1_reset_drive: assert property (@(posedge clk)
    rst |=> (bus_oe && bus_dout == '0));

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    wr_beat |=> bus_dout == $past(wr_data));

  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && rd_start) |=> !bus_oe);

  a_r4_hold_off: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RDNRM || st == ST_RDSR) && !rd_last) |=> !bus_oe);

  a_r5_repark: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDNRM && rd_last) |=> bus_oe);

  a_r6_float: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDSR && rd_last) |=> !bus_oe);

  a_r7_float_wr: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLOAT && !rd_start && wr_beat) |=> bus_oe);

  a_r8_float_exit: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FLOAT && !rd_start && !self_refresh) |=> bus_oe);

  a_r10_keep: assert property (@(posedge clk) disable iff (rst)
    !wr_beat |=> $stable(bus_dout));
endmodule

bind dbus_park_ctrl dbp_checker #(.DATA_W(DATA_W)) u_dbp_checker (
  .clk          (clk),
  .rst          (rst),
  .wr_beat      (wr_beat),
  .wr_data      (wr_data),
  .rd_start     (rd_start),
  .rd_last      (rd_last),
  .self_refresh (self_refresh),
  .bus_oe       (bus_oe),
  .bus_dout     (bus_dout),
  .st           (st)
);

// File: tb/dbus_park_ctrl_bench.sv
module dbus_park_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_beat, rd_start, rd_async, rd_last, self_refresh;
  logic [DW-1:0] wr_data;
  logic          bus_oe;
  logic [DW-1:0] bus_dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_park_ctrl #(.DATA_W(DW)) u_dbus_park_ctrl (
    .clk(clk), .rst(rst), .wr_beat(wr_beat), .wr_data(wr_data),
    .rd_start(rd_start), .rd_async(rd_async), .rd_last(rd_last),
    .self_refresh(self_refresh), .bus_oe(bus_oe), .bus_dout(bus_dout)
  );

  task automatic chk(input string req, input logic oe_exp, input logic [DW-1:0] d_exp,
                     input bit check_d);
    n_chk++;
    if (bus_oe !== oe_exp || (check_d && bus_dout !== d_exp)) begin
      n_bad++;
      $display("FAIL %s: actual oe=%b dout=%h expected oe=%b dout=%h",
               req, bus_oe, bus_dout, oe_exp, d_exp);
    end
  endtask

  task automatic clear_in();
    wr_beat = 0; rd_start = 0; rd_last = 0; rd_async = 0; wr_data = '0;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic cyc();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    wr_beat = 1; wr_data = d; cyc();
  endtask

  task automatic do_rd_start(input logic async_rd);
    rd_start = 1; rd_async = async_rd; cyc();
  endtask

  task automatic do_rd_last();
    rd_last = 1; cyc();
  endtask

  task automatic t_reset();
    rst = 1; clear_in(); self_refresh = 0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 1'b1, 16'h0000, 1);
    rst = 0; cyc();
    chk("R1 after reset", 1'b1, 16'h0000, 1);
  endtask

  task automatic t_write_park();
    do_write(16'hA5C3);
    chk("R2 write captured", 1'b1, 16'hA5C3, 1);
    cyc(); cyc();
    chk("R10 idle keeps value", 1'b1, 16'hA5C3, 1);
  endtask

  task automatic t_read_normal();
    do_rd_start(1'b0);
    chk("R3 release on read", 1'b0, 16'hA5C3, 1);
    cyc();
    chk("R4 held off idle", 1'b0, 16'hA5C3, 0);
    do_rd_start(1'b0);
    chk("R4 repeat start ignored", 1'b0, 16'hA5C3, 0);
    do_rd_last();
    chk("R5 repark after last", 1'b1, 16'hA5C3, 1);
  endtask

  task automatic t_sr_float_write();
    self_refresh = 1; cyc();
    do_rd_start(1'b1);
    chk("R3 release sr read", 1'b0, 16'hA5C3, 0);
    do_rd_last();
    chk("R6 float after sr async read", 1'b0, 16'hA5C3, 0);
    cyc(); cyc();
    chk("R6 float persists", 1'b0, 16'hA5C3, 0);
    do_write(16'h1234);
    chk("R7 write resumes parking", 1'b1, 16'h1234, 1);
  endtask

  task automatic t_sr_float_exit();
    do_rd_start(1'b1);
    do_rd_last();
    chk("R6 float again", 1'b0, 16'h1234, 0);
    self_refresh = 0; cyc();
    chk("R8 sr exit resumes parking", 1'b1, 16'h1234, 1);
  endtask

  task automatic t_read_kinds();
    self_refresh = 1; cyc();
    do_rd_start(1'b0);
    do_rd_last();
    chk("R9 sync read in sr parks", 1'b1, 16'h1234, 1);
    self_refresh = 0; cyc();
    do_rd_start(1'b1);
    self_refresh = 1;   // entering sr mid-read must not matter
    do_rd_last();
    chk("R9 async read outside sr parks", 1'b1, 16'h1234, 1);
    self_refresh = 0; cyc();
  endtask

  task automatic t_write_and_read();
    wr_beat = 1; wr_data = 16'hBEEF; rd_start = 1; cyc();
    chk("R11 same-edge write+read releases", 1'b0, 16'hBEEF, 1);
    do_rd_last();
    chk("R11 parks with new word", 1'b1, 16'hBEEF, 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write_park();
    t_read_normal();
    t_sr_float_write();
    t_sr_float_exit();
    t_read_kinds();
    t_write_and_read();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule